// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

Two eight-bit-pair timer/counters share a clock prescaler and a small register bus. Each one builds its count from a low byte and a high byte. A two-bit mode field sets how the two bytes work together: a 13-bit count, a 16-bit count, an 8-bit count that reloads from the high byte, or a special mode. Each timer counts either internal clock ticks or falling edges on its own count pin. A run bit enables it, and it can also be gated by an active-low interrupt pin. An overflow sets a flag, which drives an interrupt request. Software clears the flag by a write, or an acknowledge input clears it.

The special mode on timer 0 splits it into two 8-bit timers. The low byte keeps timer 0's controls. The high byte takes timer 1's run bit and timer 1's flag. Timer 1 then runs with no run control and sets no flag, and its overflow still appears as a one-cycle pulse for baud-rate use. Writing the special mode into timer 1's own mode field freezes timer 1.

Register map (3-bit address, 8-bit data, writes on `bus_we`, reads combinational):
- 0 run: bit0 timer 0 run, bit1 timer 1 run.
- 1 flags: bit0 timer 0 overflow, bit1 timer 1 overflow. The written value is stored.
- 2 mode: [1:0] timer 0 mode, bit2 timer 0 count-pin select, bit3 timer 0 gate, [5:4] timer 1 mode, bit6 timer 1 count-pin select, bit7 timer 1 gate.
- 3 clock: [1:0] prescale select, bit2 timer 0 uses the system clock, bit3 timer 1 uses the system clock.
- 4 timer 0 low, 5 timer 0 high, 6 timer 1 low, 7 timer 1 high.

Top module: `dual_tmr`

## Requirements
- R1: After reset every register reads 0. Run bits [7:2], flag bits [7:2] and clock bits [7:4] always read 0. All other register bits read back what was written.
- R2: Mode 01 counts the 16-bit value {high, low}. On a wrap from FFFF to 0000 it sets the timer's flag, and the flag shows on its irq output.
- R3: In mode 00 the low byte's bits [4:0] count and carry into the high byte. Bits [7:5] of the low byte keep their value. Overflow happens when the high byte is FF and the low bits are 1F.
- R4: In mode 10 a low byte at FF reloads from the high byte, sets the flag, and leaves the high byte unchanged.
- R5: A timer counts only while its run bit is 1 and, if its gate bit is 1, while its interrupt pin is high.
- R6: With count-pin select 1, the timer advances once per falling edge of its count pin, and the system-clock select bit has no effect.
- R7: With the system-clock select at 0, the count rate follows the prescale select: 00 gives one tick per 12 clocks, 01 one per 4, 10 one per 48, and 11 one per 8 rising edges of ext_clk.
- R8: A flag is cleared by writing 0 to it or by its acknowledge input. A hardware overflow in the same cycle wins.
- R9: With timer 0 in mode 11, the low byte counts as an 8-bit timer under timer 0's controls and flag. The high byte counts internal ticks while timer 1's run bit is 1, and its wrap sets timer 1's flag.
- R10: Timer 1 in mode 11 holds its count.
- R11: While timer 0 is in mode 11, timer 1 in modes 00 to 10 counts internal ticks whatever its run bit and count-pin select are, and it never sets timer 1's flag.
- R12: t1_ovf_pulse is high for one cycle per timer 1 overflow. Outside the split mode, each pulse comes with timer 1's flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| int0_n | input | 1 | Gate pin for timer 0, active low |
| int1_n | input | 1 | Gate pin for timer 1, active low |
| t0_pin | input | 1 | Event input for timer 0 |
| t1_pin | input | 1 | Event input for timer 1 |
| ext_clk | input | 1 | External clock for the divide-by-8 prescale |
| ack0 | input | 1 | Interrupt acknowledge, clears timer 0 flag |
| ack1 | input | 1 | Interrupt acknowledge, clears timer 1 flag |
| irq0 | output | 1 | Timer 0 overflow flag |
| irq1 | output | 1 | Timer 1 overflow flag |
| t1_ovf_pulse | output | 1 | One-cycle pulse per timer 1 overflow |

## Verification
The assertions assume two things about the environment. Software never writes a timer byte in the same cycle that byte is meant to count. Pin inputs stay steady long enough to pass the two-flop synchronizers. The stimulus meets both. It changes modes, counts and clock selects only while the run bits are 0, and the one exception is timer 1 in the split mode, where it opens the counting window by rewriting the mode field. Each pin level or edge is held for several clocks. Count windows are whole multiples of the prescale period, so the expected counts do not depend on the prescaler's phase.

// File: rtl/dual_tmr.sv
module dual_tmr #(
  parameter int DIV_FAST = 4,
  parameter int DIV_MID  = 12,
  parameter int DIV_SLOW = 48,
  parameter int EXT_DIV  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       int0_n,
  input  logic       int1_n,
  input  logic       t0_pin,
  input  logic       t1_pin,
  input  logic       ext_clk,
  input  logic       ack0,
  input  logic       ack1,
  output logic       irq0,
  output logic       irq1,
  output logic       t1_ovf_pulse
);
  localparam int PW = $clog2(DIV_SLOW);
  localparam int EW = $clog2(EXT_DIV);

  logic [1:0] run_q, flag_q;
  logic [7:0] mode_q;
  logic [3:0] clk_q;
  logic [7:0] tl0, th0, tl1, th1;
  logic [4:0] s1, s2;
  logic [2:0] edg_q;
  logic [PW-1:0] pre_q;
  logic [EW-1:0] ext_q;
  logic pulse_q;

  wire [1:0] m0 = mode_q[1:0];
  wire [1:0] m1 = mode_q[5:4];
  wire split = (m0 == 2'd3);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 5'b00011; s2 <= 5'b00011; edg_q <= '0;
    end else begin
      s1 <= {ext_clk, t1_pin, t0_pin, int1_n, int0_n};
      s2 <= s1;
      edg_q <= s2[4:2];
    end

  wire fall0    = edg_q[0] & ~s2[2];
  wire fall1    = edg_q[1] & ~s2[3];
  wire ext_rise = ~edg_q[2] & s2[4];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre_q <= '0; ext_q <= '0;
    end else begin
      pre_q <= (pre_q == PW'(DIV_SLOW - 1)) ? '0 : pre_q + 1'b1;
      if (ext_rise) ext_q <= (ext_q == EW'(EXT_DIV - 1)) ? '0 : ext_q + 1'b1;
    end

  wire tick_fast = (pre_q % PW'(DIV_FAST)) == PW'(DIV_FAST - 1);
  wire tick_mid  = (pre_q % PW'(DIV_MID))  == PW'(DIV_MID - 1);
  wire tick_slow = pre_q == PW'(DIV_SLOW - 1);
  wire tick_ext  = ext_rise && (ext_q == EW'(EXT_DIV - 1));

  logic ptick;
  always_comb
    case (clk_q[1:0])
      2'd0: ptick = tick_mid;
      2'd1: ptick = tick_fast;
      2'd2: ptick = tick_slow;
      default: ptick = tick_ext;
    endcase

  function automatic logic [16:0] step(input logic [1:0] m, input logic [7:0] hi, input logic [7:0] lo);
    logic [5:0] l5;
    logic [16:0] r;
    l5 = {1'b0, lo[4:0]} + 6'd1;
    case (m)
      2'd0: r = {l5[5] && (hi == 8'hFF), hi + {7'd0, l5[5]}, lo[7:5], l5[4:0]};
      2'd1: r = {1'b0, hi, lo} + 17'd1;
      2'd2: r = (lo == 8'hFF) ? {1'b1, hi, hi} : {1'b0, hi, lo + 8'd1};
      default: r = {1'b0, hi, lo};
    endcase
    return r;
  endfunction

  wire int_clk0 = clk_q[2] | ptick;
  wire int_clk1 = clk_q[3] | ptick;
  wire en0  = run_q[0] & (~mode_q[3] | s2[0]);
  wire inc0 = en0 & (mode_q[2] ? fall0 : int_clk0);
  wire hinc = split & run_q[1] & int_clk0;

  wire en1  = split | (run_q[1] & (~mode_q[7] | s2[1]));
  wire inc1 = en1 & ((mode_q[6] & ~split) ? fall1 : int_clk1);

  wire [16:0] t0_step = step(m0, th0, tl0);
  wire [16:0] t1_step = step(m1, th1, tl1);

  logic [7:0] t0_nlo, t0_nhi;
  logic set0, set1h;
  always_comb begin
    t0_nlo = tl0; t0_nhi = th0; set0 = 1'b0; set1h = 1'b0;
    if (split) begin
      if (inc0) begin t0_nlo = tl0 + 8'd1; set0 = (tl0 == 8'hFF); end
      if (hinc) begin t0_nhi = th0 + 8'd1; set1h = (th0 == 8'hFF); end
    end else if (inc0) begin
      {set0, t0_nhi, t0_nlo} = t0_step;
    end
  end

  wire ovf1 = inc1 & t1_step[16];
  wire [7:0] t1_nlo = inc1 ? t1_step[7:0]  : tl1;
  wire [7:0] t1_nhi = inc1 ? t1_step[15:8] : th1;
  wire set1 = split ? set1h : ovf1;

  wire [7:0] wsel = bus_we ? (8'd1 << bus_addr) : 8'd0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run_q <= '0; flag_q <= '0; mode_q <= '0; clk_q <= '0;
      tl0 <= '0; th0 <= '0; tl1 <= '0; th1 <= '0; pulse_q <= 1'b0;
    end else begin
      if (wsel[0]) run_q  <= bus_wdata[1:0];
      if (wsel[2]) mode_q <= bus_wdata;
      if (wsel[3]) clk_q  <= bus_wdata[3:0];
      flag_q[0] <= set0 | (~ack0 & (wsel[1] ? bus_wdata[0] : flag_q[0]));
      flag_q[1] <= set1 | (~ack1 & (wsel[1] ? bus_wdata[1] : flag_q[1]));
      tl0 <= wsel[4] ? bus_wdata : t0_nlo;
      th0 <= wsel[5] ? bus_wdata : t0_nhi;
      tl1 <= wsel[6] ? bus_wdata : t1_nlo;
      th1 <= wsel[7] ? bus_wdata : t1_nhi;
      pulse_q <= ovf1;
    end

  always_comb
    case (bus_addr)
      3'd0: bus_rdata = {6'd0, run_q};
      3'd1: bus_rdata = {6'd0, flag_q};
      3'd2: bus_rdata = mode_q;
      3'd3: bus_rdata = {4'd0, clk_q};
      3'd4: bus_rdata = tl0;
      3'd5: bus_rdata = th0;
      3'd6: bus_rdata = tl1;
      default: bus_rdata = th1;
    endcase

  assign irq0 = flag_q[0];
  assign irq1 = flag_q[1];
  assign t1_ovf_pulse = pulse_q;
endmodule

// File: rtl/dual_tmr_chk.sv
module dual_tmr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       we,
  input logic [2:0] addr,
  input logic [7:0] mode,
  input logic [1:0] run,
  input logic [1:0] flag,
  input logic       ack0,
  input logic       set0,
  input logic [7:0] tl0,
  input logic [7:0] th0,
  input logic [7:0] tl1,
  input logic [7:0] th1,
  input logic       pulse
);
  wire split = mode[1:0] == 2'd3;

  a_r3_upper_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1:0] == 2'd0 && !(we && addr == 3'd4)) |=> $stable(tl0[7:5]));

  a_r4_reload_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1:0] == 2'd2 && !(we && addr == 3'd5)) |=> $stable(th0));

  a_r5_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!split && !run[0] && !(we && (addr == 3'd4 || addr == 3'd5))) |=> $stable({th0, tl0}));

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack0 && !set0) |=> !flag[0]);

  a_r10_t1_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[5:4] == 2'd3 && !(we && addr[2:1] == 2'b11)) |=> $stable({th1, tl1}));

  a_r11_quiet_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (split && th0 != 8'hFF && !(we && addr == 3'd1)) |=> !$rose(flag[1]));

  a_r12_pulse_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !$past(split)) |-> flag[1]);
endmodule

bind dual_tmr dual_tmr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .mode(mode_q),
  .run(run_q), .flag(flag_q), .ack0(ack0), .set0(set0),
  .tl0(tl0), .th0(th0), .tl1(tl1), .th1(th1), .pulse(t1_ovf_pulse)
);

// File: tb/dual_tmr_tb.sv
module dual_tmr_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic int0_n = 1, int1_n = 1, t0_pin = 0, t1_pin = 0;
  logic ack0 = 0, ack1 = 0, irq0, irq1, t1_ovf_pulse;
  logic ext_on = 0;
  logic [3:0] ecnt = 0;
  wire ext_clk = ecnt[1];
  int total = 0, bad = 0, pcount = 0, pbase;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) begin
    if (ext_on) ecnt = ecnt + 1;
    if (t1_ovf_pulse) pcount = pcount + 1;
  end

  dual_tmr u_dut (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .int0_n(int0_n), .int1_n(int1_n),
    .t0_pin(t0_pin), .t1_pin(t1_pin), .ext_clk(ext_clk), .ack0(ack0), .ack1(ack1),
    .irq0(irq0), .irq1(irq1), .t1_ovf_pulse(t1_ovf_pulse));

  localparam logic [18:0] VEC [12] = '{
    {3'd0, 8'hFC, 8'h00}, {3'd1, 8'hFE, 8'h02}, {3'd1, 8'h00, 8'h00},
    {3'd2, 8'hA5, 8'hA5}, {3'd2, 8'h00, 8'h00}, {3'd3, 8'hFF, 8'h0F},
    {3'd3, 8'h00, 8'h00}, {3'd4, 8'h5A, 8'h5A}, {3'd5, 8'hC3, 8'hC3},
    {3'd6, 8'h3C, 8'h3C}, {3'd7, 8'h96, 8'h96}, {3'd4, 8'h00, 8'h00}};

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    bus_addr = a; #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic window(input int w, input logic [7:0] rv);
    wr(3'd0, rv);
    repeat (w - 1) @(negedge clk);
    wr(3'd0, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 8; a++) rd_chk("R1 reset", 3'(a), 8'h00);
    for (int i = 0; i < 12; i++) begin
      wr(VEC[i][18:16], VEC[i][15:8]);
      rd_chk("R1 readback", VEC[i][18:16], VEC[i][7:0]);
    end

    // R2 16-bit wrap
    wr(2, 8'h01); wr(3, 8'h04); wr(4, 8'hF0); wr(5, 8'hFF); wr(1, 0);
    window(16, 8'h01);
    rd_chk("R2 low", 4, 8'h00); rd_chk("R2 high", 5, 8'h00);
    rd_chk("R2 flag", 1, 8'h01); chk("R2 irq0", {7'd0, irq0}, 8'h01);
    window(5, 8'h01);
    rd_chk("R2 after wrap", 4, 8'h05);

    // R8 flag clearing
    ack0 = 1; @(negedge clk); ack0 = 0;
    rd_chk("R8 ack", 1, 8'h00);
    wr(1, 8'h03); wr(1, 8'h02);
    rd_chk("R8 write0", 1, 8'h02); chk("R8 irq1", {7'd0, irq1}, 8'h01);
    ack1 = 1; @(negedge clk); ack1 = 0;
    rd_chk("R8 ack1", 1, 8'h00);

    // R3 13-bit
    wr(2, 8'h00); wr(5, 8'hFF); wr(4, 8'hFD);
    window(3, 8'h01);
    rd_chk("R3 low", 4, 8'hE0); rd_chk("R3 high", 5, 8'h00); rd_chk("R3 flag", 1, 8'h01);
    wr(1, 0);

    // R4 reload
    wr(2, 8'h02); wr(5, 8'h80); wr(4, 8'hFE);
    window(2, 8'h01);
    rd_chk("R4 reload", 4, 8'h80); rd_chk("R4 flag", 1, 8'h01);
    window(3, 8'h01);
    rd_chk("R4 low", 4, 8'h83); rd_chk("R4 high kept", 5, 8'h80);
    wr(1, 0);

    // R5 gating
    wr(2, 8'h09); wr(4, 0); wr(5, 0); int0_n = 0;
    repeat (5) @(negedge clk);
    window(20, 8'h01);
    rd_chk("R5 gated", 4, 8'h00);
    int0_n = 1; repeat (5) @(negedge clk);
    window(20, 8'h01);
    rd_chk("R5 open", 4, 8'h14);
    window(20, 8'h00);
    rd_chk("R5 run off", 4, 8'h14);

    // R6 counter function
    wr(2, 8'h05); wr(4, 0);
    wr(0, 8'h01);
    for (int k = 0; k < 7; k++) begin
      t0_pin = 1; repeat (4) @(negedge clk);
      t0_pin = 0; repeat (4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    wr(0, 0);
    rd_chk("R6 events", 4, 8'h07);

    // R7 prescaler
    wr(2, 8'h01); wr(3, 8'h00); wr(4, 0);
    window(120, 8'h01); rd_chk("R7 div12", 4, 8'h0A);
    wr(3, 8'h01); wr(4, 0);
    window(120, 8'h01); rd_chk("R7 div4", 4, 8'h1E);
    wr(3, 8'h02); wr(4, 0);
    window(480, 8'h01); rd_chk("R7 div48", 4, 8'h0A);
    ext_on = 1; wr(3, 8'h03); wr(4, 0);
    repeat (64) @(negedge clk);
    window(256, 8'h01); rd_chk("R7 ext div8", 4, 8'h08);
    ext_on = 0;

    // R9 split timer 0
    wr(2, 8'h03); wr(3, 8'h04); wr(4, 0); wr(5, 8'hFE); wr(1, 0);
    window(2, 8'h02);
    rd_chk("R9 high wrap", 5, 8'h00); rd_chk("R9 low idle", 4, 8'h00);
    rd_chk("R9 t1 flag", 1, 8'h02);
    wr(1, 0);
    window(5, 8'h01);
    rd_chk("R9 low", 4, 8'h05); rd_chk("R9 high idle", 5, 8'h00);

    // R10 timer 1 stopped
    wr(2, 8'h30); wr(3, 8'h08); wr(6, 8'h11);
    window(10, 8'h02);
    rd_chk("R10 hold", 6, 8'h11);

    // R11 timer 1 while timer 0 split
    wr(2, 8'h73); wr(3, 8'h08); wr(6, 8'hF0); wr(7, 8'hFF); wr(1, 0);
    pbase = pcount;
    wr(2, 8'h53);
    repeat (19) @(negedge clk);
    wr(2, 8'h73);
    repeat (3) @(negedge clk);
    rd_chk("R11 low", 6, 8'h04); rd_chk("R11 high", 7, 8'h00);
    rd_chk("R11 no flag", 1, 8'h00);
    chk("R11 pulse", 8'(pcount - pbase), 8'd1);

    // R12 pulse in reload mode
    wr(2, 8'h21); wr(6, 8'hFC); wr(7, 8'hFC); wr(1, 0);
    pbase = pcount;
    window(8, 8'h02);
    repeat (3) @(negedge clk);
    rd_chk("R12 low", 6, 8'hFC); rd_chk("R12 flag", 1, 8'h02);
    chk("R12 pulses", 8'(pcount - pbase), 8'd2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule